// File: doc/BRIEF.md
# Iterative Sign-Magnitude Integer Divider

This unit performs one integer division at a time for a 64-bit processor pipeline. The requester supplies two unsigned magnitudes (dividend and divisor), a set of mode flags and a small bookkeeping payload. The payload is a destination register tag and a record-condition bit. The mode flags select:

- a half-width (32-bit) operation;
- an extended form, in which the dividend is shifted up by the operand width;
- remainder output instead of quotient;
- a negate flag that turns the final value into its two's complement;
- a signed flag that enables the signed range check on quotients.

Taking absolute values and working out the negate flag happen upstream. For a quotient, the requester sets the negate flag to the XOR of the operand signs. For a remainder, it sets the flag to the dividend sign alone. The unit applies the flag without knowing which of these two cases produced it.

The core is a restoring shift-subtract loop. It runs one quotient bit per clock, and the same registers end up holding both the quotient and the remainder. After the loop, one combinational stage does four things: it picks quotient or remainder, applies the negation, widens a half-width value to 64 bits, and forces the result to zero on overflow.

Requests enter through a valid/ready handshake. `in_ready` is high only while the unit is idle and no flush is being applied. A request transfers on a rising edge where both `in_valid` and `in_ready` are high. A valid that is raised while ready is low is not stored, so the requester must keep the request up until ready returns. The result side has no back-pressure. A one-cycle `out_done` strobe marks a new result. The result, the overflow flag, the tag and the record bit then hold until the next completion.

Top module: `div_unit_top`

## Requirements
- R1: `in_ready` is high exactly when the unit is idle and `flush` is low. A request is taken on an edge where `in_valid` and `in_ready` are both high. An `in_valid` raised while `in_ready` is low has no effect on any later result.
- R2: In full-width, non-extended mode, the unit computes the unsigned quotient of dividend by divisor. With `in_mod`=1 it outputs the remainder instead.
- R3: With `in_neg`=1, the selected quotient or remainder is replaced by its two's complement, taken modulo 2^64 in full-width mode and modulo 2^32 in half-width mode.
- R4: In full-width extended mode, the numerator is dividend·2^64. If the dividend is greater than or equal to the divisor, the result is zero and `out_ovf`=1.
- R5: In half-width mode (`in_is32`=1), only bits 31:0 of each operand are used. The 32-bit result is sign-extended from bit 31 to 64 bits when `in_neg`=1, and zero-extended when `in_neg`=0.
- R6: In half-width extended mode, the numerator is dividend[31:0]·2^32. If dividend[31:0] is greater than or equal to divisor[31:0], the result is zero and `out_ovf`=1.
- R7: A divisor of zero (within the active width) completes with normal timing, result zero and `out_ovf`=1.
- R8: With `in_signed`=1 and quotient output selected, the quotient magnitude may be at most 2^(W-1)-1 when `in_neg`=0, and at most 2^(W-1) when `in_neg`=1, where W is 32 or 64. A larger quotient gives result zero and `out_ovf`=1.
- R9: `out_done` is high for one cycle, N+1 rising edges after the accepting edge. N is 32 for half-width non-extended requests and 64 for all other requests. The result, overflow flag, tag and record bit change only at that edge.
- R10: `out_tag` and `out_rec` deliver the tag and record bit of the request that completed, unchanged.
- R11: Synchronous `rst` aborts any operation in progress and clears every output register to zero. `flush` aborts any operation in progress and suppresses its `out_done`, but leaves the held result as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Abort the operation in progress, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_dividend | input | 64 | Dividend magnitude |
| in_divisor | input | 64 | Divisor magnitude |
| in_is32 | input | 1 | Half-width (32-bit) operation |
| in_ext | input | 1 | Extended form: dividend shifted up by the operand width |
| in_mod | input | 1 | Output remainder instead of quotient |
| in_neg | input | 1 | Negate the final result |
| in_signed | input | 1 | Apply the signed quotient range check |
| in_tag | input | 5 | Destination register tag |
| in_rec | input | 1 | Record-condition bit |
| out_done | output | 1 | One-cycle completion strobe |
| out_result | output | 64 | Result value, held |
| out_ovf | output | 1 | Overflow or divide-by-zero, held |
| out_tag | output | 5 | Tag of the completed request, held |
| out_rec | output | 1 | Record bit of the completed request, held |

## Verification
The division path is exercised with the following input patterns:

- Small and all-ones 64-bit operands, which separate quotient selection from remainder selection.
- Negated variants, which show whether the two's complement and the sign-extension of half-width results are applied.
- Extended requests on both sides of the dividend-versus-divisor boundary, which tell a correct shifted numerator apart from an overflowed one.
- Divisors that are zero only in their low half, which tell whether the half-width masking reaches the zero check.
- Quotients placed exactly at the signed limit and one past it, which pin down the signed range rule for each sign.

Requests raised while the unit is busy, flushes applied both mid-loop and in the final cycle, a reset in mid-operation, and back-to-back requests show that the handshake and abort rules neither lose a result nor invent one.

// File: rtl/div_unit_pkg.sv
package div_unit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic half;       // 32-bit operation
    logic ext;        // dividend shifted up by operand width
    logic rem_sel;    // output remainder
    logic negate;     // two's-complement the final value
    logic signed_op;  // apply signed quotient range check
  } div_mode_t;

endpackage

// File: rtl/div_setup.sv
module div_setup
  import div_unit_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CW   = $clog2(XLEN + 1)
) (
  input  div_mode_t         mode,
  input  logic [XLEN-1:0]   dividend,
  input  logic [XLEN-1:0]   divisor,
  output logic [XLEN:0]     rem_init,
  output logic [XLEN-1:0]   quo_init,
  output logic [XLEN-1:0]   den_init,
  output logic [CW-1:0]     iters,
  output logic              mag_ge
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] mag;

  always_comb begin
    if (mode.half) begin
      mag      = {{HALF{1'b0}}, dividend[HALF-1:0]};
      den_init = {{HALF{1'b0}}, divisor[HALF-1:0]};
      rem_init = '0;
      // half-width numerator sits in the top half of the shift register
      quo_init = {dividend[HALF-1:0], {HALF{1'b0}}};
      iters    = mode.ext ? CW'(XLEN) : CW'(HALF);
    end else begin
      mag      = dividend;
      den_init = divisor;
      // extended: dividend is the high half of a double-width numerator
      rem_init = mode.ext ? {1'b0, dividend} : '0;
      quo_init = mode.ext ? '0 : dividend;
      iters    = CW'(XLEN);
    end
    mag_ge = (mag >= den_init);
  end

endmodule

// File: rtl/div_step_core.sv
module div_step_core #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              load,
  input  logic              step,
  input  logic [XLEN:0]     rem_init,
  input  logic [XLEN-1:0]   quo_init,
  input  logic [XLEN-1:0]   den_init,
  output logic [XLEN:0]     rem,
  output logic [XLEN-1:0]   quo,
  output logic [XLEN-1:0]   den
);
  logic [XLEN:0] shifted;
  logic [XLEN:0] diff;
  logic          take;

  always_comb begin
    shifted = {rem[XLEN-1:0], quo[XLEN-1]};
    take    = (shifted >= {1'b0, den});
    diff    = shifted - {1'b0, den};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rem <= rem_init;
      quo <= quo_init;
      den <= den_init;
    end else if (step) begin
      rem <= take ? diff : shifted;
      quo <= {quo[XLEN-2:0], take};
    end
  end

endmodule

// File: rtl/div_finish.sv
module div_finish
  import div_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  div_mode_t         mode,
  input  logic [XLEN-1:0]   quo,
  input  logic [XLEN-1:0]   rem,
  input  logic [XLEN-1:0]   den,
  input  logic              mag_ge,
  output logic [XLEN-1:0]   result,
  output logic              ovf
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] qval, lim, sel, negv, shaped;
  logic            den0, sovf;

  always_comb begin
    qval = mode.half ? {{HALF{1'b0}}, quo[HALF-1:0]} : quo;
    lim  = mode.half ? (XLEN'(1) << (HALF - 1)) : (XLEN'(1) << (XLEN - 1));
    if (!mode.negate) lim = lim - XLEN'(1);
    den0 = (den == '0);
    sovf = mode.signed_op && !mode.rem_sel && (qval > lim);
    ovf  = den0 || (mode.ext && mag_ge) || sovf;
    sel  = mode.rem_sel ? rem : qval;
    negv = mode.negate ? ('0 - sel) : sel;
    if (mode.half)
      shaped = mode.negate ? {{HALF{negv[HALF-1]}}, negv[HALF-1:0]}
                           : {{HALF{1'b0}}, negv[HALF-1:0]};
    else
      shaped = negv;
    result = ovf ? '0 : shaped;
  end

endmodule

// File: rtl/div_unit_top.sv
module div_unit_top
  import div_unit_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_dividend,
  input  logic [XLEN-1:0]  in_divisor,
  input  logic             in_is32,
  input  logic             in_ext,
  input  logic             in_mod,
  input  logic             in_neg,
  input  logic             in_signed,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_rec,
  output logic             out_done,
  output logic [XLEN-1:0]  out_result,
  output logic             out_ovf,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_rec
);
  localparam int CW = $clog2(XLEN + 1);

  div_state_e       state;
  div_mode_t        in_mode, mode_q;
  logic [CW-1:0]    cnt, iters;
  logic [TAG_W-1:0] tag_q;
  logic             rec_q, mag_ge, mag_ge_q;
  logic             accept, step_en;
  logic [XLEN:0]    rem_init, step_rem;
  logic [XLEN-1:0]  quo_init, den_init, step_quo, step_den;
  logic [XLEN-1:0]  fin_result;
  logic             fin_ovf;

  assign in_mode  = '{half: in_is32, ext: in_ext, rem_sel: in_mod,
                      negate: in_neg, signed_op: in_signed};
  assign in_ready = (state == ST_IDLE) && !flush;
  assign accept   = in_valid && in_ready && !rst;
  assign step_en  = (state == ST_RUN) && !flush && !rst;

  div_setup #(.XLEN(XLEN), .CW(CW)) setup_i (
    .mode(in_mode), .dividend(in_dividend), .divisor(in_divisor),
    .rem_init(rem_init), .quo_init(quo_init), .den_init(den_init),
    .iters(iters), .mag_ge(mag_ge)
  );

  div_step_core #(.XLEN(XLEN)) core_i (
    .clk(clk), .load(accept), .step(step_en),
    .rem_init(rem_init), .quo_init(quo_init), .den_init(den_init),
    .rem(step_rem), .quo(step_quo), .den(step_den)
  );

  div_finish #(.XLEN(XLEN)) finish_i (
    .mode(mode_q), .quo(step_quo), .rem(step_rem[XLEN-1:0]),
    .den(step_den), .mag_ge(mag_ge_q),
    .result(fin_result), .ovf(fin_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      mode_q     <= '0;
      mag_ge_q   <= 1'b0;
      tag_q      <= '0;
      rec_q      <= 1'b0;
      out_done   <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_tag    <= '0;
      out_rec    <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (flush) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (accept) begin
            mode_q   <= in_mode;
            mag_ge_q <= mag_ge;
            tag_q    <= in_tag;
            rec_q    <= in_rec;
            cnt      <= iters;
            state    <= ST_RUN;
          end
          ST_RUN: begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) state <= ST_FIN;
          end
          ST_FIN: begin
            out_result <= fin_result;
            out_ovf    <= fin_ovf;
            out_tag    <= tag_q;
            out_rec    <= rec_q;
            out_done   <= 1'b1;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cnt != '0 && cnt <= CW'(XLEN)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

  // R11
  flush_kill_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_done);

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && step_den != '0 && !(mode_q.ext && mag_ge_q))
      |-> (step_rem < {1'b0, step_den}));

endmodule

// File: tb/div_unit_top_tb.sv
`timescale 1ns/1ps
module div_unit_top_tb_top;
  logic        clk = 1'b0;
  logic        rst, flush, in_valid, in_ready;
  logic [63:0] in_dividend, in_divisor;
  logic        in_is32, in_ext, in_mod, in_neg, in_signed, in_rec;
  logic [4:0]  in_tag;
  logic        out_done, out_ovf, out_rec;
  logic [63:0] out_result;
  logic [4:0]  out_tag;

  int checks = 0;
  int errors = 0;
  bit run_chk = 0;

  always #2 clk = ~clk;

  div_unit_top dut_i (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_is32(in_is32),
    .in_ext(in_ext), .in_mod(in_mod), .in_neg(in_neg), .in_signed(in_signed),
    .in_tag(in_tag), .in_rec(in_rec), .out_done(out_done), .out_result(out_result),
    .out_ovf(out_ovf), .out_tag(out_tag), .out_rec(out_rec)
  );

  function automatic logic [64:0] ref_div(logic [63:0] a, logic [63:0] b,
                                          bit h, bit e, bit md, bit ng, bit sg);
    logic [127:0] num, den, q, r, lim, mag;
    logic [63:0]  sel, o;
    bit           ov;
    if (h) begin
      den = {96'b0, b[31:0]};
      mag = {96'b0, a[31:0]};
      num = e ? {64'b0, a[31:0], 32'b0} : {96'b0, a[31:0]};
    end else begin
      den = {64'b0, b};
      mag = {64'b0, a};
      num = e ? {a, 64'b0} : {64'b0, a};
    end
    ov = (den == 0) || (e && mag >= den);
    q = 0;
    r = 0;
    if (!ov) begin
      q = num / den;
      r = num % den;
      if (sg && !md) begin
        lim = h ? 128'h8000_0000 : 128'h8000_0000_0000_0000;
        if (!ng) lim = lim - 1;
        if (q > lim) ov = 1;
      end
    end
    if (ov) return {1'b1, 64'b0};
    sel = md ? r[63:0] : q[63:0];
    if (ng) sel = -sel;
    if (h) o = ng ? {{32{sel[31]}}, sel[31:0]} : {32'b0, sel[31:0]};
    else   o = sel;
    return {1'b0, o};
  endfunction

  // behavioural reference: countdown to completion, held outputs
  int          cd = 0;
  bit          m_done = 0, m_ovf = 0, m_rec = 0, p_rec = 0;
  logic [63:0] m_res = '0;
  logic [4:0]  m_tag = '0, p_tag = '0;
  logic [64:0] p_val = '0;
  string       m_req = "R11 reset state", p_req = "", cur_req = "";

  always @(posedge clk) begin
    if (rst) begin
      cd = 0; m_done = 0; m_res = '0; m_ovf = 0; m_tag = '0; m_rec = 0;
      m_req = "R11 reset state";
    end else if (flush) begin
      cd = 0; m_done = 0;
    end else if (cd > 0) begin
      cd--;
      m_done = (cd == 0);
      if (m_done) begin
        {m_ovf, m_res} = p_val;
        m_tag = p_tag;
        m_rec = p_rec;
        m_req = p_req;
      end
    end else begin
      m_done = 0;
      if (in_valid) begin
        p_val = ref_div(in_dividend, in_divisor, in_is32, in_ext, in_mod, in_neg, in_signed);
        p_tag = in_tag;
        p_rec = in_rec;
        p_req = cur_req;
        cd = (in_is32 && !in_ext) ? 33 : 65;
      end
    end
  end

  task automatic chk(bit ok, string what, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (run_chk && !rst) begin
      chk(in_ready == ((cd == 0) && !flush), "R1 ready",
          65'(in_ready), 65'((cd == 0) && !flush));
      chk(out_done == m_done, "R9 R11 done strobe", 65'(out_done), 65'(m_done));
      chk({out_ovf, out_result} == {m_ovf, m_res}, {m_req, " result/ovf"},
          {out_ovf, out_result}, {m_ovf, m_res});
      chk({out_rec, out_tag} == {m_rec, m_tag}, "R10 tag/rec",
          65'({out_rec, out_tag}), 65'({m_rec, m_tag}));
    end
  end

  task automatic op(string req, logic [63:0] a, logic [63:0] b,
                    bit h, bit e, bit md, bit ng, bit sg, logic [4:0] tg, bit rc);
    while (cd != 0) @(negedge clk);
    cur_req = req;
    in_dividend = a; in_divisor = b;
    in_is32 = h; in_ext = e; in_mod = md; in_neg = ng; in_signed = sg;
    in_tag = tg; in_rec = rc;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (cd != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; flush = 0; in_valid = 0; in_dividend = '0; in_divisor = '0;
    in_is32 = 0; in_ext = 0; in_mod = 0; in_neg = 0; in_signed = 0;
    in_tag = '0; in_rec = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    run_chk = 1;
    @(negedge clk);
    #1;
    chk(out_result == '0 && !out_done && in_ready, "R11 reset state",
        {out_done, out_result}, 65'(0));

    // R2 plain full-width
    op("R2 quotient", 64'd1000, 64'd7, 0, 0, 0, 0, 0, 5'd3, 1);
    op("R2 remainder", 64'd1000, 64'd7, 0, 0, 1, 0, 0, 5'd17, 0);
    op("R2 all-ones quotient", 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, 0, 0, 5'd31, 1);
    // R3 negation
    op("R3 negated quotient", 64'd100, 64'd7, 0, 0, 0, 1, 1, 5'd1, 0);
    op("R3 negated remainder", 64'd100, 64'd7, 0, 0, 1, 1, 1, 5'd2, 1);
    // R4 full-width extended
    op("R4 extended quotient", 64'd5, 64'h10, 0, 1, 0, 0, 0, 5'd4, 0);
    op("R4 extended remainder", 64'd5, 64'd7, 0, 1, 1, 0, 0, 5'd5, 0);
    op("R4 extended overflow", 64'd16, 64'd16, 0, 1, 0, 0, 0, 5'd6, 1);
    // R5 half-width, junk upper bits
    op("R5 half quotient", 64'hDEAD_BEEF_0000_0064, 64'hFFFF_0000_0000_0007, 1, 0, 0, 0, 0, 5'd7, 0);
    op("R5 half negated sign-extend", 64'h0000_0000_0000_0064, 64'd7, 1, 0, 0, 1, 1, 5'd8, 1);
    op("R5 half zero-extend", 64'h1234_5678_F000_0000, 64'd1, 1, 0, 0, 0, 0, 5'd9, 0);
    // R6 half-width extended
    op("R6 half extended quotient", 64'd3, 64'd7, 1, 1, 0, 0, 0, 5'd10, 1);
    op("R6 half extended overflow", 64'hFFFF_FFFF_0000_0007, 64'd7, 1, 1, 0, 0, 0, 5'd11, 0);
    // R7 divide by zero
    op("R7 full-width zero divisor", 64'd55, 64'd0, 0, 0, 0, 0, 0, 5'd12, 1);
    op("R7 half zero divisor low half", 64'd55, 64'hABCD_0000_0000_0000, 1, 0, 1, 0, 0, 5'd13, 0);
    // R8 signed range
    op("R8 signed limit positive overflow", 64'h8000_0000_0000_0000, 64'd1, 0, 0, 0, 0, 1, 5'd14, 0);
    op("R8 signed limit negative fits", 64'h8000_0000_0000_0000, 64'd1, 0, 0, 0, 1, 1, 5'd15, 1);
    op("R8 half signed limit negative", 64'h8000_0000, 64'd1, 1, 0, 0, 1, 1, 5'd16, 0);
    op("R8 half signed overflow", 64'h8000_0000, 64'd1, 1, 0, 0, 0, 1, 5'd18, 1);
    wait_idle();

    // R1 valid while busy is ignored
    op("R1 busy request ignored", 64'd999, 64'd10, 0, 0, 0, 0, 0, 5'd20, 1);
    for (int i = 0; i < 5; i++) begin
      in_dividend = 64'd1; in_divisor = 64'd1; in_tag = 5'd21; in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_idle();

    // R11 flush in mid-loop
    op("R11 flushed mid-loop", 64'd77, 64'd5, 0, 0, 0, 0, 0, 5'd22, 0);
    repeat (10) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    repeat (80) @(negedge clk);
    // R11 flush in the final cycle of a half-width request
    op("R11 flushed at finish", 64'd77, 64'd5, 1, 0, 0, 0, 0, 5'd23, 1);
    repeat (31) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk(!out_done && out_tag == 5'd20, "R11 flush keeps held result",
        65'({out_done, out_tag}), 65'(20));

    // R11 reset in mid-operation
    op("R11 reset mid-operation", 64'd500, 64'd3, 0, 0, 0, 0, 0, 5'd24, 1);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(out_result == '0 && out_tag == '0 && in_ready, "R11 reset clears outputs",
        {in_ready, out_result}, {1'b1, 64'b0});
    repeat (80) @(negedge clk);

    // back-to-back after reset
    op("R2 back-to-back first", 64'd81, 64'd9, 0, 0, 0, 0, 0, 5'd25, 0);
    op("R5 back-to-back second", 64'd81, 64'd4, 1, 0, 1, 0, 0, 5'd26, 1);
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule